// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Parity

This block turns bytes into an asynchronous serial bit stream. A producer offers a byte with a valid/ready handshake. The block accepts it only while the line is idle, and stores the byte and the parity selection together. It then sends a frame on a single output wire. Every bit of the frame lasts exactly one period of an external baud-rate tick. Between frames the wire rests high, and a busy flag is raised from the cycle after acceptance until the frame is finished.

The frame has a low start bit, then the data bits starting with the least-significant, then an optional parity bit, then one high stop bit. A 3-bit selector picks the parity slot:
- even parity;
- odd parity;
- a constant one;
- a constant zero;
- no parity slot at all, so that the stop bit follows the last data bit directly.

Top module: `uart_par_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0, `txd` is 1.
- R2: `in_ready` is 1 exactly when `busy` is 0. A byte is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `busy` is 1 from the next cycle on. The start bit appears after the first later edge at which `baud_tick` is 1; a tick in the acceptance cycle itself does not start the frame.
- R3: The frame is sent as start (0), then D0 through D7 with the LSB first, then the parity bit if one is enabled, then stop (1). `txd` changes only at edges where `baud_tick` is 1, so each bit lasts one tick period. `busy` falls at the tick that ends the stop bit.
- R4: With `par_mode` = 0 (even), the parity bit is the XOR of the eight data bits. For byte 0x41 this gives 0.
- R5: With `par_mode` = 1 (odd), the parity bit is the inverse of the XOR of the data bits. For byte 0x41 this gives 1.
- R6: With `par_mode` = 2 (space), the parity bit is 0 for every byte.
- R7: With `par_mode` = 3 (mark), the parity bit is 1 for every byte.
- R8: With `par_mode` = 4, 5, 6 or 7 (no parity), no parity bit is sent. The frame is 10 bits long, and the stop bit directly follows D7.
- R9: The data and `par_mode` are captured at acceptance. Changes to them during a frame do not alter that frame.
- R10: `in_valid` held high while `busy` is 1 is not accepted. The byte offered on those inputs is taken only once the block is idle again, and it is then sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| par_mode | input | 3 | Parity selection: 0 even, 1 odd, 2 space, 3 mark, 4 to 7 none |
| in_data | input | 8 | Byte offered for sending |
| in_valid | input | 1 | `in_data` and `par_mode` are valid |
| in_ready | output | 1 | The block can accept a byte this cycle |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | A frame is pending or being sent |

## Verification
Two events can fall in the same clock cycle: acceptance of a byte and a baud tick. The tick must not start the newly accepted frame. The bench provokes this by running the tick on every cycle, and also at several slower divisions, while bytes are offered back to back.

A second overlap is the tick that ends a stop bit arriving while `in_valid` is already held for the next byte. That byte must be taken only in the following cycle.

A behavioural model built from a queue of bits judges both cases. It is compared against `txd`, `busy` and `in_ready` on every clock. The captured parity slot of each frame is also checked against hand-worked values.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] PM_EVEN  = 3'd0;
    localparam logic [MODE_W-1:0] PM_ODD   = 3'd1;
    localparam logic [MODE_W-1:0] PM_SPACE = 3'd2;
    localparam logic [MODE_W-1:0] PM_MARK  = 3'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARMED,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    typedef struct packed {
        logic en;
        logic val;
    } par_slot_t;

    // Parity slot from the selector and the XOR of all data bits.
    function automatic par_slot_t calc_slot(logic [MODE_W-1:0] mode, logic ones_odd);
        par_slot_t s;
        s.en  = 1'b1;
        s.val = 1'b0;
        case (mode)
            PM_EVEN:  s.val = ones_odd;
            PM_ODD:   s.val = ~ones_odd;
            PM_SPACE: s.val = 1'b0;
            PM_MARK:  s.val = 1'b1;
            default:  s.en  = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uart_tx_latch.sv
module uart_tx_latch
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] data_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic [DATA_W-1:0] data_q,
    output logic [MODE_W-1:0] mode_q
);
    // Capture data and mode together at acceptance (R9).
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mode_q <= '0;
        end else if (take) begin
            data_q <= data_in;
            mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_q,
    input  logic [MODE_W-1:0] mode_q,
    output par_slot_t         slot
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^data_q;
        slot     = calc_slot(mode_q, ones_odd);
    end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              take,
    input  logic [DATA_W-1:0] data_q,
    input  par_slot_t         slot,
    output logic              txd,
    output logic              idle
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_phase_e        phase;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;

    assign idx_nxt = idx + 1'b1;
    assign idle    = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            txd   <= 1'b1;
            idx   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    txd <= 1'b1;
                    if (take) phase <= PH_ARMED;
                end
                PH_ARMED: begin
                    if (tick) begin
                        txd   <= 1'b0;
                        phase <= PH_START;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        txd   <= data_q[0];
                        idx   <= '0;
                        phase <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        if (idx == LAST_IDX) begin
                            if (slot.en) begin
                                txd   <= slot.val;
                                phase <= PH_PARITY;
                            end else begin
                                txd   <= 1'b1;
                                phase <= PH_STOP;
                            end
                        end else begin
                            idx <= idx_nxt;
                            txd <= data_q[idx_nxt];
                        end
                    end
                end
                PH_PARITY: begin
                    if (tick) begin
                        txd   <= 1'b1;
                        phase <= PH_STOP;
                    end
                end
                PH_STOP: begin
                    if (tick) phase <= PH_IDLE;
                end
                default: begin
                    phase <= PH_IDLE;
                    txd   <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [2:0]        par_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);
    logic              take;
    logic              idle;
    logic [DATA_W-1:0] data_q;
    logic [MODE_W-1:0] mode_q;
    par_slot_t         slot;

    assign in_ready = idle;
    assign busy     = ~idle;
    assign take     = in_valid & idle;

    uart_tx_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst(rst), .take(take),
        .data_in(in_data), .mode_in(par_mode),
        .data_q(data_q), .mode_q(mode_q)
    );

    uart_tx_parity #(.DATA_W(DATA_W)) u_parity (
        .data_q(data_q), .mode_q(mode_q), .slot(slot)
    );

    uart_tx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .tick(baud_tick), .take(take),
        .data_q(data_q), .slot(slot), .txd(txd), .idle(idle)
    );
endmodule

module uart_par_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);                                                    // R1
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        in_ready == !busy);                                                // R2
    AST_ACCEPT_ARMS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && txd));                         // R2
    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(txd));                                      // R3
    AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> busy);                                    // R3
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);                                               // R10
endmodule

bind uart_par_tx uart_par_tx_chk u_chk (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .txd(txd), .busy(busy)
);

// File: tb/uart_par_tx_bench.sv
module uart_par_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, txd, busy;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int tick_div = 4;
    int tick_cnt = 0;
    string tag = "R3";

    // reference model
    bit   m_busy = 0;
    bit   m_line = 1;
    bit   q[$];
    bit   cap[$];
    bit   popped = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    uart_par_tx u_uart_par_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .par_mode(par_mode),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .txd(txd), .busy(busy)
    );

    function automatic bit ref_parity(input logic [7:0] d, input logic [2:0] m,
                                      output bit has);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        has = 1;
        case (m)
            3'd0: return (ones % 2) == 1;
            3'd1: return (ones % 2) == 0;
            3'd2: return 0;
            3'd3: return 1;
            default: begin has = 0; return 0; end
        endcase
    endfunction

    always @(posedge clk) begin
        popped <= 0;
        if (rst) begin
            m_busy <= 0; m_line <= 1; q.delete();
        end else if (!m_busy) begin
            if (in_valid) begin
                bit has, p;
                p = ref_parity(in_data, par_mode, has);
                q.delete(); cap.delete();
                q.push_back(0);
                for (int i = 0; i < 8; i++) q.push_back(in_data[i]);
                if (has) q.push_back(p);
                q.push_back(1);
                m_busy <= 1;
            end
        end else if (baud_tick) begin
            if (q.size() > 0) begin
                m_line <= q.pop_front();
                popped <= 1;
            end else begin
                m_busy <= 0;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (popped) cap.push_back(txd);
            check(tag, "txd", txd, m_line);
            check("R2", "busy", busy, m_busy);
            check("R2", "in_ready", in_ready, !m_busy);
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            tick_cnt <= 0; baud_tick <= 0;
        end else begin
            baud_tick <= (tick_cnt >= tick_div - 1);
            tick_cnt  <= (tick_cnt >= tick_div - 1) ? 0 : tick_cnt + 1;
        end
    end

    task automatic send(input logic [7:0] d, input logic [2:0] m);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = d; par_mode = m; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic send_check(input logic [7:0] d, input logic [2:0] m,
                              input int exp_par, input string req);
        send(d, m);
        wait_idle();
        if (exp_par < 0) begin
            check(req, "frame length", cap.size(), 10);
            check(req, "bit after D7", cap[9], 1);
        end else begin
            check(req, "frame length", cap.size(), 11);
            check(req, "parity slot", cap[9], exp_par);
        end
        check("R3", "start bit", cap[0], 0);
        check("R3", "D0", cap[1], d[0]);
        check("R3", "D7", cap[8], d[7]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", "reset txd", txd, 1);
        check("R1", "reset busy", busy, 0);
        check("R1", "reset in_ready", in_ready, 1);

        // parity of 0x41 in every mode
        send_check(8'h41, 3'd0, 0, "R4");
        send_check(8'h41, 3'd1, 1, "R5");
        send_check(8'h41, 3'd2, 0, "R6");
        send_check(8'h41, 3'd3, 1, "R7");
        send_check(8'h41, 3'd4, -1, "R8");
        send_check(8'h41, 3'd7, -1, "R8");
        send_check(8'hA7, 3'd0, 1, "R4");
        send_check(8'hA7, 3'd1, 0, "R5");
        send_check(8'h00, 3'd3, 1, "R7");
        send_check(8'hFF, 3'd2, 0, "R6");

        // tick every cycle: acceptance and tick collide
        tick_div = 1;
        send_check(8'h5C, 3'd1, 1, "R2");
        send_check(8'h3B, 3'd5, -1, "R8");

        // inputs changed mid-frame, valid held while busy
        tick_div = 3;
        tag = "R9";
        send(8'h41, 3'd0);
        in_data = 8'h7E; par_mode = 3'd3; in_valid = 1;
        wait_idle();
        check("R9", "parity kept despite mode change", cap[9], 0);
        check("R9", "D6 kept despite data change", cap[7], 1);
        tag = "R10";
        @(negedge clk);
        in_valid = 0;
        wait_idle();
        check("R10", "held byte sent after idle, parity", cap[9], 1);
        check("R10", "held byte D1", cap[2], 1);

        // varied patterns, rates and modes
        tag = "R3";
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            d = 8'(k * 37 + 11);
            tick_div = 1 + (k % 5);
            send(d, 3'(k % 8));
        end
        wait_idle();
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule